// File: doc/BRIEF.md
# Interlaken Metaframe Synchronizer and CRC Checker

This block sits on the receive side of a lane, after block delineation and descrambling. It takes one 66-bit word per valid cycle (a 2-bit header plus a 64-bit payload) and looks for the metaframe sync control word. When that word recurs at the programmed metaframe spacing, the block declares lock. While locked, it follows the metaframe boundaries with a position counter, so a single damaged sync word does not cost it the boundary.

While lock is held, the block pulses a frame-start flag at the first word of every metaframe. It also recomputes a CRC-32 over each metaframe, with the CRC field of the closing diagnostic word taken as zero, and compares the result with that field. The 2-bit status carried by each valid diagnostic word is latched and held on a dedicated output. The metaframe length comes from a static input and must match the transmitter.

Top module: `imf_sync`

## Requirements
- R1: After reset, the outputs are as follows: `locked` is 0, `frame_start` is 0, `crc_err` is 0 and `diag_status` is 2'b00.
- R2: Word classes:
  - A sync word has header 2'b10 and payload bits [63:58] = 6'b011110.
  - A valid diagnostic word has header 2'b10 and bits [63:58] = 6'b011001.
  - Any other word is ordinary.
  - A cycle with `in_valid` low changes no state and gives no `frame_start` pulse, whatever it carries.
- R3: Acquiring lock:
  - From search, a sync word starts a candidate boundary.
  - `locked` rises in the cycle after the fourth consecutive sync word seen exactly `mf_len` valid words after the previous one.
  - A non-sync word at an expected position before lock sends the block back to search.
  - `mf_len` may be any value from 5 to 8192.
- R4: Losing lock:
  - While locked, four consecutive expected sync positions without a sync word drop `locked` in the cycle after the fourth.
  - Any sync word at an expected position clears the miss count.
  - After the drop, the search restarts.
- R5: `frame_start` is a one-cycle pulse. It appears in the cycle after each word at an expected sync position whenever lock is held after that word, including the word that achieves lock. It appears at no other time.
- R6: CRC definition and check:
  - The CRC-32 uses polynomial 0x1EDC6F41, non-reflected. The register is preset to all ones at the first word of a metaframe. Each 64-bit payload is fed most significant bit first. The result is inverted.
  - The last word of the metaframe (position `mf_len`-1) is fed with bits [31:0] zeroed, and the result is compared with its bits [31:0].
  - On a locked metaframe, `crc_err` takes the outcome of that comparison in the cycle after the last word and holds it until the next check. A last word that is not a valid diagnostic word counts as a failure.
- R7: `diag_status` loads bits [33:32] of every valid diagnostic word in the cycle after it. It keeps its value across all other words, including diagnostic-typed words with a wrong header.
- R8: Whenever `locked` is 0, `crc_err` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_len | input | 14 | Metaframe length in words, 5 to 8192 |
| in_valid | input | 1 | Qualifies the word on this cycle |
| in_hdr | input | 2 | Word header (2'b10 control, 2'b01 data) |
| in_word | input | 64 | Word payload |
| locked | output | 1 | Metaframe lock achieved |
| frame_start | output | 1 | First word of a metaframe accepted while locked |
| crc_err | output | 1 | CRC check of the last locked metaframe failed |
| diag_status | output | 2 | Status bits of the latest valid diagnostic word |

## Verification
The hardest state to reach is the boundary between keeping and losing lock while the block is coasting on its position counter. This covers three cases:
- three missing sync words followed by a good one, which must keep lock;
- four missing sync words, which must drop it;
- a broken run of sync words during acquisition.

The bench reaches these cases with frames whose sync word carries a data header. It combines them with idle cycles that carry sync-looking payloads. Random phases at two lengths mix damaged frames of this kind with corrupted payloads and mis-headed diagnostic words. A final phase at the 8192-word limit checks acquisition and the CRC at the longest spacing.

// File: rtl/imf_sync.sv
module imf_sync #(
  parameter int LEN_W       = 14,
  parameter int LOCK_HITS   = 4,
  parameter int DROP_MISSES = 4,
  parameter logic [31:0] POLY = 32'h1EDC6F41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] mf_len,
  input  logic             in_valid,
  input  logic [1:0]       in_hdr,
  input  logic [63:0]      in_word,
  output logic             locked,
  output logic             frame_start,
  output logic             crc_err,
  output logic [1:0]       diag_status
);

  localparam int POS_W = LEN_W - 1;
  localparam int CMAX  = (LOCK_HITS > DROP_MISSES) ? LOCK_HITS : DROP_MISSES;
  localparam int CW    = $clog2(CMAX) + 1;
  localparam logic [5:0] SYNC_T = 6'b011110;
  localparam logic [5:0] DIAG_T = 6'b011001;

  typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_LOCK} st_t;

  st_t             st, st_n;
  logic [POS_W-1:0] pos;
  logic [CW-1:0]   hits, hits_n, miss, miss_n;
  logic [31:0]     crc_q, crc_in, crc_nxt;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [63:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 63; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  wire ctl_w    = (in_hdr == 2'b10);
  wire sync_w   = ctl_w && (in_word[63:58] == SYNC_T);
  wire diag_w   = ctl_w && (in_word[63:58] == DIAG_T);
  wire last_pos = ({1'b0, pos} == (mf_len - 1'b1));
  wire at_start = (st == ST_HUNT) ? sync_w : (pos == '0);
  wire crc_pass;

  assign crc_in   = at_start ? 32'hFFFF_FFFF : crc_q;
  assign crc_nxt  = crc_step(crc_in, last_pos ? {in_word[63:32], 32'h0} : in_word);
  assign crc_pass = diag_w && ((~crc_nxt) == in_word[31:0]);
  assign locked   = (st == ST_LOCK);

  always_comb begin
    st_n   = st;
    hits_n = hits;
    miss_n = miss;
    if (in_valid) begin
      case (st)
        ST_HUNT:
          if (sync_w) begin
            st_n   = ST_CONFIRM;
            hits_n = CW'(1);
          end
        ST_CONFIRM:
          if (at_start) begin
            if (!sync_w) st_n = ST_HUNT;
            else if (hits == CW'(LOCK_HITS - 1)) begin
              st_n   = ST_LOCK;
              miss_n = '0;
            end else hits_n = hits + 1'b1;
          end
        ST_LOCK:
          if (at_start) begin
            if (sync_w) miss_n = '0;
            else if (miss == CW'(DROP_MISSES - 1)) st_n = ST_HUNT;
            else miss_n = miss + 1'b1;
          end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_HUNT;
      pos         <= '0;
      hits        <= '0;
      miss        <= '0;
      crc_q       <= '0;
      frame_start <= 1'b0;
      crc_err     <= 1'b0;
      diag_status <= 2'b00;
    end else begin
      st          <= st_n;
      hits        <= hits_n;
      miss        <= miss_n;
      frame_start <= in_valid && at_start && (st_n == ST_LOCK);
      if (in_valid) begin
        crc_q <= crc_nxt;
        if (st_n == ST_HUNT)  pos <= '0;
        else if (at_start)    pos <= POS_W'(1);
        else if (last_pos)    pos <= '0;
        else                  pos <= pos + 1'b1;
        if (diag_w) diag_status <= in_word[33:32];
      end
      if (st_n != ST_LOCK) crc_err <= 1'b0;
      else if (in_valid && st == ST_LOCK && last_pos) crc_err <= !crc_pass;
    end
  end

  p_start_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> locked);
  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !crc_err);
  p_lock_on_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_valid && sync_w));
  p_drop_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(in_valid && !sync_w));
  p_diag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && diag_w) |-> $stable(diag_status));
  p_idle_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(locked) && !frame_start));

endmodule

// File: tb/imf_sync_bench.sv
module imf_sync_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] mf_len = 14'd5;
  logic        in_valid = 1'b0;
  logic [1:0]  in_hdr = 2'b00;
  logic [63:0] in_word = '0;
  logic        locked, frame_start, crc_err;
  logic [1:0]  diag_status;

  int total = 0, bad = 0;
  int ms, mpos, mhits, mmiss;
  logic [31:0] mcrc;
  logic e_lock, e_fs, e_err;
  logic [1:0] e_diag;

  always #10 clk = ~clk;

  imf_sync u_imf_sync (
    .clk(clk), .rst_n(rst_n), .mf_len(mf_len), .in_valid(in_valid),
    .in_hdr(in_hdr), .in_word(in_word), .locked(locked),
    .frame_start(frame_start), .crc_err(crc_err), .diag_status(diag_status));

  function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [63:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 63; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ 32'h1EDC6F41;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    ms = 0; mpos = 0; mhits = 0; mmiss = 0; mcrc = '0;
    e_lock = 0; e_fs = 0; e_err = 0; e_diag = 2'b00;
  endtask

  task automatic do_reset(input int len);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; mf_len = 14'(len);
    model_reset();
    repeat (2) @(negedge clk);
    check(locked == 0, "R1 locked", 32'(locked), 0);
    check(frame_start == 0, "R1 frame_start", 32'(frame_start), 0);
    check(crc_err == 0, "R1 crc_err", 32'(crc_err), 0);
    check(diag_status == 0, "R1 diag_status", 32'(diag_status), 0);
    rst_n = 1'b1;
  endtask

  task automatic send_word(input logic v, input logic [1:0] h, input logic [63:0] w);
    logic sy, dg, at0, lastp;
    int ns, L;
    logic [31:0] calc;
    @(negedge clk);
    in_valid = v; in_hdr = h; in_word = w;
    L = int'(mf_len);
    if (v) begin
      sy = (h == 2'b10) && (w[63:58] == 6'b011110);
      dg = (h == 2'b10) && (w[63:58] == 6'b011001);
      at0 = (ms == 0) ? sy : (mpos == 0);
      lastp = (ms != 0) && (mpos == L - 1);
      ns = ms;
      if (ms == 0) begin
        if (sy) begin ns = 1; mhits = 1; end
      end else if (ms == 1) begin
        if (at0) begin
          if (!sy) ns = 0;
          else if (mhits == 3) begin ns = 2; mmiss = 0; end
          else mhits++;
        end
      end else if (at0) begin
        if (sy) mmiss = 0;
        else if (mmiss == 3) ns = 0;
        else mmiss++;
      end
      if (ms == 2 && lastp) begin
        calc = ~bcrc(mcrc, {w[63:32], 32'h0});
        e_err = !(dg && calc == w[31:0]);
      end
      mcrc = at0 ? bcrc(32'hFFFF_FFFF, w) : bcrc(mcrc, w);
      if (ns == 0) mpos = 0;
      else if (at0) mpos = 1;
      else if (lastp) mpos = 0;
      else mpos++;
      e_fs = at0 && (ns == 2);
      if (dg) e_diag = w[33:32];
      ms = ns;
      if (ns != 2) e_err = 0;
      e_lock = (ns == 2);
    end else e_fs = 0;
    @(posedge clk);
    #2;
    check(locked == e_lock, "R3/R4 locked", 32'(locked), 32'(e_lock));
    check(frame_start == e_fs, "R5 frame_start", 32'(frame_start), 32'(e_fs));
    check(crc_err == e_err, "R6 crc_err", 32'(crc_err), 32'(e_err));
    check(diag_status == e_diag, "R7 diag_status", 32'(diag_status), 32'(e_diag));
    check(locked || (!crc_err && !frame_start), "R8 quiet while unlocked",
          32'({crc_err, frame_start}), 0);
  endtask

  task automatic send_frame(input bit no_sync, input bit flip, input bit bad_diag, input int idle_pct);
    logic [31:0] c;
    logic [63:0] w;
    logic [1:0]  h;
    int L;
    L = int'(mf_len);
    c = '0;
    for (int k = 0; k < L; k++) begin
      while (int'($urandom_range(99)) < idle_pct)
        send_word(1'b0, 2'b10, {6'b011110, 58'($urandom())});
      if (k == 0) begin
        w = {6'b011110, 58'(rnd64())};
        h = no_sync ? 2'b01 : 2'b10;
        c = bcrc(32'hFFFF_FFFF, w);
      end else if (k == L - 1) begin
        w = {6'b011001, 24'($urandom()), 2'($urandom()), 32'h0};
        w[31:0] = ~bcrc(c, w);
        h = bad_diag ? 2'b01 : 2'b10;
      end else begin
        w = rnd64();
        h = 2'b01;
        if ($urandom_range(9) == 0) begin w[63:58] = 6'b000011; h = 2'b10; end
        c = bcrc(c, w);
        if (flip && k == 1) w[5] = ~w[5];
      end
      send_word(1'b1, h, w);
    end
  endtask

  initial begin
    #(20 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] held;
    void'($urandom(32'd20240611));
    do_reset(5);
    // R2: idle cycles carrying sync payloads change nothing
    for (int i = 0; i < 3; i++) send_word(1'b0, 2'b10, {6'b011110, 58'h0});
    check(locked == 0, "R2 idle ignored", 32'(locked), 0);
    for (int i = 0; i < 3; i++) send_word(1'b1, 2'b01, rnd64());
    send_frame(0, 0, 0, 0);
    send_frame(0, 0, 0, 0);
    send_frame(1, 0, 0, 0);
    send_frame(0, 0, 0, 0);
    send_frame(0, 0, 0, 0);
    send_frame(0, 0, 0, 0);
    check(locked == 0, "R3 restart after broken run", 32'(locked), 0);
    send_frame(0, 0, 0, 30);
    check(locked == 1, "R3 lock after four syncs", 32'(locked), 1);
    send_frame(0, 1, 0, 0);
    check(crc_err == 1, "R6 corrupted payload flagged", 32'(crc_err), 1);
    send_frame(0, 0, 0, 0);
    check(crc_err == 0, "R6 clean frame clears", 32'(crc_err), 0);
    held = diag_status;
    send_frame(0, 0, 1, 0);
    check(diag_status == held, "R7 bad header not latched", 32'(diag_status), 32'(held));
    check(crc_err == 1, "R6 missing diag word fails", 32'(crc_err), 1);
    for (int i = 0; i < 3; i++) send_frame(1, 0, 0, 0);
    check(locked == 1, "R4 three misses keep lock", 32'(locked), 1);
    send_frame(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) send_frame(1, 0, 0, 0);
    check(locked == 1, "R4 miss count cleared", 32'(locked), 1);
    for (int i = 0; i < 4; i++) send_frame(1, 0, 0, 0);
    check(locked == 0, "R4 four misses drop lock", 32'(locked), 0);
    check(crc_err == 0, "R8 crc_err low after drop", 32'(crc_err), 0);

    for (int p = 0; p < 2; p++) begin
      do_reset(p == 0 ? 8 : 37);
      for (int f = 0; f < 60; f++) begin
        int r;
        r = int'($urandom_range(9));
        send_frame(r == 0 || r == 1, r == 2, r == 3, 20);
      end
    end

    do_reset(8192);
    for (int i = 0; i < 5; i++) send_frame(0, 0, 0, 0);
    check(locked == 1, "R3 lock at longest spacing", 32'(locked), 1);
    check(crc_err == 0, "R6 clean at longest spacing", 32'(crc_err), 0);
    send_frame(0, 1, 0, 0);
    check(crc_err == 1, "R6 corruption at longest spacing", 32'(crc_err), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule